// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts rendered video lines and raises an interrupt request when a programmed number of lines has passed. It is an 8-bit down-counter. A counting pulse comes from the video timing once per rendered line: the scanline number and the dot-cycle number are compared against a fixed dot position. Pulses are only produced on the visible lines and on the pre-render line, and only while background or sprite rendering is enabled.

The CPU controls the block with writes. The top three address bits select one of two register pairs, and address bit 0 picks the member of the pair. One write stores a reload value. One write forces a reload on the next counting pulse. The other two writes disable or enable the interrupt. When the count reaches zero, whether by decrementing or by reloading, and the interrupt is enabled, the request is raised. The request stays high until the CPU acknowledges it or disables the interrupt.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset the request is low, the counter, the reload value, the reload-pending flag and the enable are all zero. An enable followed by a counting pulse therefore raises the request at once.
- R2: A write whose top three address bits are 110 and whose address bit 0 is 0 stores the data byte as the reload value.
- R3: A write whose top three address bits are 110 and whose address bit 0 is 1 clears the counter and sets the reload-pending flag. The next counting pulse loads the reload value, even when this write comes in the middle of a count.
- R4: A write whose top three address bits are 111 and whose address bit 0 is 0 disables the interrupt and drops a pending request in the following cycle.
- R5: A write whose top three address bits are 111 and whose address bit 0 is 1 enables the interrupt. Enabling does not by itself raise the request.
- R6: A counting pulse occurs only under all of these conditions:
  - the dot cycle equals TICK_DOT (default 260);
  - the scanline is at most LAST_VISIBLE (default 239), or equals PRE_LINE (default 261);
  - rendering is enabled.

  The pulse lasts one cycle for each arrival at that dot, however long the dot value is held.
- R7: On a counting pulse, the counter loads the reload value and the pending flag clears if the counter is zero or a reload is pending. Otherwise the counter decrements by one.
- R8: If the counter is zero after a counting pulse and the interrupt is enabled, the request is set in that clock cycle. With a reload value of 0, this happens on every pulse.
- R9: A one-cycle acknowledge clears the request.
- R10: Writes whose top two address bits are not both 1 have no effect on the counter, the reload value or the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| scan_line | input | 9 | Current scanline number from the video timing |
| dot_cycle | input | 9 | Current dot cycle within the line |
| render_on | input | 1 | High while background or sprite rendering is enabled |
| irq_ack | input | 1 | Acknowledge, clears the request |
| irq_req | output | 1 | Interrupt request |

## Verification
A reload value of 3 separates three silent pulses from the fourth, which raises the request, and from the fifth, which reloads without raising it. This tells a decrement-to-zero apart from a reload. A reload forced in the middle of a count of 5 must restart the count from a new value. A reload value of 0 must raise the request on every pulse. Several stimuli must not move the count, and this is shown by the request arriving on exactly the expected later pulse:
- pulses with rendering off;
- a non-rendered line;
- a neighbouring dot;
- a held dot value;
- writes outside the control range.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_LATCH   = 3'd1,
    CMD_RELOAD  = 3'd2,
    CMD_DISABLE = 3'd3,
    CMD_ENABLE  = 3'd4
  } sirq_cmd_e;

  // Map a CPU write to a command from top three address bits and parity.
  function automatic sirq_cmd_e decode_cmd(input logic we, input logic [2:0] top3,
                                           input logic odd);
    sirq_cmd_e c;
    c = CMD_NONE;
    if (we) begin
      if (top3 == 3'b110)      c = odd ? CMD_RELOAD : CMD_LATCH;
      else if (top3 == 3'b111) c = odd ? CMD_ENABLE : CMD_DISABLE;
    end
    return c;
  endfunction

  // Next count on a counting pulse.
  function automatic logic [7:0] step_count(input logic [7:0] cnt, input logic [7:0] rld,
                                            input logic pend);
    if (cnt == 8'd0 || pend) return rld;
    return cnt - 8'd1;
  endfunction

endpackage

// File: rtl/sirq_regdec.sv
module sirq_regdec
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output sirq_cmd_e         cmd
);
  localparam int TOP_LSB = ADDR_W - 3;

  always_comb begin
    cmd = decode_cmd(we, addr[ADDR_W-1:TOP_LSB], addr[0]);
  end
endmodule

// File: rtl/sirq_tickgen.sv
module sirq_tickgen #(
  parameter int LINE_W       = 9,
  parameter int DOT_W        = 9,
  parameter int TICK_DOT     = 260,
  parameter int LAST_VISIBLE = 239,
  parameter int PRE_LINE     = 261
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line,
  input  logic [DOT_W-1:0]  dot,
  input  logic              render_on,
  output logic              tick
);
  localparam logic [DOT_W-1:0]  DOT_V  = DOT_W'(TICK_DOT);
  localparam logic [LINE_W-1:0] LAST_V = LINE_W'(LAST_VISIBLE);
  localparam logic [LINE_W-1:0] PRE_V  = LINE_W'(PRE_LINE);

  logic line_ok;
  logic match;
  logic match_q;

  always_comb begin
    line_ok = (line <= LAST_V) || (line == PRE_V);
    match   = render_on && line_ok && (dot == DOT_V);
    tick    = match && !match_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match;
  end
endmodule

// File: rtl/sirq_core.sv
module sirq_core
  import sirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sirq_cmd_e        cmd,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  input  logic             ack,
  output logic             irq,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] latch_o,
  output logic             pending_o,
  output logic             enable_o,
  output logic             set_evt
);
  logic [CNT_W-1:0] count_q, latch_q, cnt_upd;
  logic             pend_q, en_q, irq_q, pend_upd;

  always_comb begin
    cnt_upd  = count_q;
    pend_upd = pend_q;
    if (tick) begin
      cnt_upd  = CNT_W'(step_count(8'(count_q), 8'(latch_q), pend_q));
      pend_upd = 1'b0;
    end
    set_evt = tick && (cnt_upd == '0) && en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      latch_q <= '0;
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= (cmd == CMD_RELOAD) ? '0 : cnt_upd;
      pend_q  <= (cmd == CMD_RELOAD) ? 1'b1 : pend_upd;
      if (cmd == CMD_LATCH) latch_q <= wdata;
      if (cmd == CMD_DISABLE)     en_q <= 1'b0;
      else if (cmd == CMD_ENABLE) en_q <= 1'b1;
      if (cmd == CMD_DISABLE) irq_q <= 1'b0;
      else if (set_evt)       irq_q <= 1'b1;
      else if (ack)           irq_q <= 1'b0;
    end
  end

  assign irq       = irq_q;
  assign count_o   = count_q;
  assign latch_o   = latch_q;
  assign pending_o = pend_q;
  assign enable_o  = en_q;
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import sirq_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CNT_W        = 8,
  parameter int LINE_W       = 9,
  parameter int DOT_W        = 9,
  parameter int TICK_DOT     = 260,
  parameter int LAST_VISIBLE = 239,
  parameter int PRE_LINE     = 261
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CNT_W-1:0]  cpu_wdata,
  input  logic [LINE_W-1:0] scan_line,
  input  logic [DOT_W-1:0]  dot_cycle,
  input  logic              render_on,
  input  logic              irq_ack,
  output logic              irq_req
);
  sirq_cmd_e        cmd;
  logic             tick_evt;
  logic             set_evt;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] latch_q;
  logic             pending_q;
  logic             enable_q;
  logic             reload_wr_evt;
  logic             latch_wr_evt;
  logic             disable_wr_evt;

  sirq_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .we(cpu_we), .addr(cpu_addr), .cmd(cmd)
  );

  sirq_tickgen #(
    .LINE_W(LINE_W), .DOT_W(DOT_W), .TICK_DOT(TICK_DOT),
    .LAST_VISIBLE(LAST_VISIBLE), .PRE_LINE(PRE_LINE)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .line(scan_line), .dot(dot_cycle),
    .render_on(render_on), .tick(tick_evt)
  );

  sirq_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(cpu_wdata), .tick(tick_evt),
    .ack(irq_ack), .irq(irq_req), .count_o(count_q), .latch_o(latch_q),
    .pending_o(pending_q), .enable_o(enable_q), .set_evt(set_evt)
  );

  assign reload_wr_evt  = (cmd == CMD_RELOAD);
  assign latch_wr_evt   = (cmd == CMD_LATCH);
  assign disable_wr_evt = (cmd == CMD_DISABLE);
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             render_on,
  input logic             irq_ack,
  input logic             irq_req,
  input logic             tick_evt,
  input logic             set_evt,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] latch_q,
  input logic             pending_q,
  input logic             enable_q,
  input logic             reload_wr_evt,
  input logic             latch_wr_evt,
  input logic             disable_wr_evt
);
  AST_NO_TICK_WHEN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !render_on |-> !tick_evt); // R6
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> !tick_evt); // R6
  AST_RELOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt && (count_q == '0 || pending_q) && !reload_wr_evt
      |=> count_q == $past(latch_q) && !pending_q); // R7
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt && count_q != '0 && !pending_q && !reload_wr_evt
      |=> count_q == $past(count_q) - 1'b1); // R7
  AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr_evt |=> count_q == '0 && pending_q); // R3
  AST_LATCH_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_wr_evt |=> $stable(latch_q)); // R2
  AST_IRQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(tick_evt) && $past(enable_q)); // R8
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    disable_wr_evt |=> !irq_req && !enable_q); // R4
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !set_evt |=> !irq_req); // R9
endmodule

bind scanline_irq_counter sirq_checker #(.CNT_W(CNT_W)) u_sirq_chk (
  .clk(clk), .rst_n(rst_n), .render_on(render_on), .irq_ack(irq_ack),
  .irq_req(irq_req), .tick_evt(tick_evt), .set_evt(set_evt), .count_q(count_q),
  .latch_q(latch_q), .pending_q(pending_q), .enable_q(enable_q),
  .reload_wr_evt(reload_wr_evt), .latch_wr_evt(latch_wr_evt),
  .disable_wr_evt(disable_wr_evt)
);

// File: tb/scanline_irq_counter_bench.sv
module scanline_irq_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [8:0]  scan_line = '0;
  logic [8:0]  dot_cycle = '0;
  logic        render_on = 1'b1;
  logic        irq_ack = 1'b0;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scanline_irq_counter u_scanline_irq_counter (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .scan_line(scan_line), .dot_cycle(dot_cycle),
    .render_on(render_on), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq_req actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  // Present one dot position for 'hold' cycles, then move away from it.
  task automatic pulse(input int line, input int dot, input logic ren, input int hold);
    @(negedge clk);
    scan_line = 9'(line); dot_cycle = 9'(dot); render_on = ren;
    repeat (hold) @(negedge clk);
    dot_cycle = 9'd0; render_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic tick(input int line);
    pulse(line, 260, 1'b1, 1);
  endtask

  task automatic t_reset();
    check(irq_req, 1'b0, "R1 reset");
    cpu_write(16'hE001, 8'h00);
    check(irq_req, 1'b0, "R5 enable alone");
    tick(10);
    check(irq_req, 1'b1, "R1 zero reload value");
    ack();
    check(irq_req, 1'b0, "R9 ack");
  endtask

  task automatic t_count();
    cpu_write(16'hC000, 8'd3);
    cpu_write(16'hC001, 8'h00);
    for (int i = 0; i < 3; i++) begin
      tick(20 + i);
      check(irq_req, 1'b0, "R7 counting");
    end
    tick(30);
    check(irq_req, 1'b1, "R8 decrement to zero R2");
    ack();
    check(irq_req, 1'b0, "R9 ack after count");
    tick(31);
    check(irq_req, 1'b0, "R7 reload from zero");
  endtask

  task automatic t_midreload();
    cpu_write(16'hC000, 8'd5);
    cpu_write(16'hC001, 8'h00);
    tick(40);
    tick(41);
    cpu_write(16'hDFFE, 8'd2);
    cpu_write(16'hDFFF, 8'h00);
    tick(42);
    check(irq_req, 1'b0, "R3 reload mid count");
    tick(43);
    check(irq_req, 1'b0, "R3 count one");
    tick(44);
    check(irq_req, 1'b1, "R3 restarted count reaches zero");
  endtask

  task automatic t_disable();
    cpu_write(16'hE000, 8'h00);
    check(irq_req, 1'b0, "R4 disable drops request");
    cpu_write(16'hFFFF, 8'h00);
    check(irq_req, 1'b0, "R5 enable does not raise");
  endtask

  task automatic t_render();
    cpu_write(16'hC000, 8'd1);
    cpu_write(16'hC001, 8'h00);
    pulse(50, 260, 1'b1, 3);
    check(irq_req, 1'b0, "R6 held dot counts once");
    pulse(51, 260, 1'b0, 1);
    check(irq_req, 1'b0, "R6 rendering off");
    pulse(240, 260, 1'b1, 1);
    check(irq_req, 1'b0, "R6 line 240");
    pulse(52, 259, 1'b1, 1);
    check(irq_req, 1'b0, "R6 dot 259");
    tick(261);
    check(irq_req, 1'b1, "R6 pre-render line counts");
    ack();
  endtask

  task automatic t_latch0();
    cpu_write(16'hC000, 8'd0);
    cpu_write(16'hC001, 8'h00);
    tick(60);
    check(irq_req, 1'b1, "R8 zero reload first");
    ack();
    tick(61);
    check(irq_req, 1'b1, "R8 zero reload every pulse");
    ack();
  endtask

  task automatic t_ignored();
    cpu_write(16'hC000, 8'd2);
    cpu_write(16'hC001, 8'h00);
    tick(70);
    cpu_write(16'h8000, 8'h55);
    cpu_write(16'hA001, 8'h55);
    cpu_write(16'h6000, 8'h55);
    cpu_write(16'h9FFF, 8'h55);
    check(irq_req, 1'b0, "R10 stray writes");
    tick(71);
    check(irq_req, 1'b0, "R10 count one");
    tick(72);
    check(irq_req, 1'b1, "R10 count unaffected");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_midreload();
    t_disable();
    t_render();
    t_latch0();
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog irq_req actual %0b expected finish", irq_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule